// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches six status conditions of one serial channel and raises an interrupt when any enabled one changes. The six conditions are break/abort, transmit underrun or end of message, clear-to-send, sync/hunt, carrier detect and baud counter zero count. Each raw input first crosses into the local clock domain through a small synchronizer. A per-source enable byte selects which conditions may interrupt. Both a rising and a falling transition count as a change.

When an enabled transition is seen, the block captures a snapshot of all six condition levels and sets a pending flag. The snapshot then stays frozen in the status byte until software issues a reset-status command, so the level software reads is the one that caused the interrupt. Two buffer-state bits in the same byte, transmit buffer empty and receive character available, are never frozen and always show their live inputs. After the command, the frozen snapshot serves as the reference for the next comparison. A condition that moved while the latch was frozen is therefore reported again at once and is not lost.

The interrupt request output is the pending flag gated by two enables: a per-channel status interrupt enable and a master interrupt enable. All control and status pins are plain levels or single-cycle strobes. No data streams through this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `esl_status_latch`

## Requirements
- R1: During and after reset, the status byte shows 0 in all six condition bits (bits 7..3 and bit 1), `pend_o` is 0 and `irq_o` is 0.
- R2: A 0-to-1 change on a raw condition input whose enable bit is set raises `pend_o` on the third rising clock edge after the change: two synchronizer stages, then the latch.
- R3: A 1-to-0 change on an enabled condition input raises `pend_o` with the same latency as R2.
- R4: A change on a condition whose enable bit is clear never sets `pend_o`. While nothing is pending, that condition's status bit follows its synchronized input with the R2 latency.
- R5: While `pend_o` is 1 and no reset-status command arrives, `pend_o` stays 1. The six condition bits of the status byte hold the values captured when pending was set, whatever the inputs do.
- R6: Status bit 2 always equals `txe_i` and status bit 0 always equals `rxa_i`, with no delay, frozen or not.
- R7: A one-cycle `clr_cmd_i` while pending clears `pend_o` at the next edge. A `clr_cmd_i` while nothing is pending changes nothing.
- R8: After a clear, comparison resumes against the held snapshot. An enabled condition whose synchronized level differs from the snapshot sets `pend_o` again one edge after the clear, and the new level is captured.
- R9: `irq_o` is 1 exactly when `pend_o`, `stat_ie_i` and `master_ie_i` are all 1. It follows the enables with no delay.
- R10: Enable bit positions are: break 0x80, underrun 0x40, CTS 0x20, sync/hunt 0x10, carrier detect 0x08, zero count 0x02. Bits 0x04 and 0x01 of `src_en_i` have no effect.
- R11: Status byte layout is: break 0x80, underrun 0x40, CTS 0x20, sync/hunt 0x10, carrier detect 0x08, transmit empty 0x04, zero count 0x02, receive available 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_i | input | 1 | Raw break/abort condition |
| txund_i | input | 1 | Raw transmit underrun / end of message |
| cts_i | input | 1 | Raw clear-to-send |
| synch_i | input | 1 | Raw sync/hunt condition |
| dcd_i | input | 1 | Raw carrier detect |
| zcnt_i | input | 1 | Raw baud counter zero count |
| txe_i | input | 1 | Transmit buffer empty (already local) |
| rxa_i | input | 1 | Receive character available (already local) |
| src_en_i | input | 8 | Per-source change enable byte |
| stat_ie_i | input | 1 | Channel status interrupt enable |
| master_ie_i | input | 1 | Master interrupt enable |
| clr_cmd_i | input | 1 | Reset-status command strobe |
| status_o | output | 8 | Status byte |
| pend_o | output | 1 | Status change pending |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Directed patterns isolate single behaviours, each with one transition:
- a rising and then a falling edge on one enabled source, which separates the two edge polarities and measures the synchronizer latency;
- a toggle on a source with its enable clear, and a toggle enabled only through the unused enable bits, which shows that the mask is applied at the right positions;
- a source that moves while the latch is frozen, which shows that the held snapshot, not the live level, is the reference after a clear.

Random toggling of all six sources then runs against a cycle model in the bench. The toggling is mixed with random clears, enable changes and buffer bits, which exposes same-cycle collisions such as a clear arriving together with a new edge.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam int NSRC   = 6;
  localparam int STAT_W = 8;

  // Source vector order, LSB first: zero count, carrier detect, sync/hunt,
  // CTS, underrun, break.
  function automatic logic [NSRC-1:0] pick_enables(input logic [STAT_W-1:0] en);
    return {en[7], en[6], en[5], en[4], en[3], en[1]};
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NSRC-1:0] s,
                                                    input logic txe,
                                                    input logic rxa);
    return {s[5:1], txe, s[0], rxa};
  endfunction
endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[LAST];
endmodule

// File: rtl/esl_change_latch.sv
module esl_change_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic         clr,
  output logic [W-1:0] snap,
  output logic         pend
);
  logic [W-1:0] snap_q;
  logic         pend_q;
  logic [W-1:0] diff;

  // The snapshot doubles as the edge reference: while armed it trails the
  // synchronized level by one cycle, while pending it holds the capture.
  assign diff = (lvl ^ snap_q) & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (clr) pend_q <= 1'b0;
    end else begin
      snap_q <= lvl;
      pend_q <= |diff;
    end
  end

  assign snap = snap_q;
  assign pend = pend_q;
endmodule

// File: rtl/esl_status_latch.sv
module esl_status_latch
  import esl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_i,
  input  logic              txund_i,
  input  logic              cts_i,
  input  logic              synch_i,
  input  logic              dcd_i,
  input  logic              zcnt_i,
  input  logic              txe_i,
  input  logic              rxa_i,
  input  logic [STAT_W-1:0] src_en_i,
  input  logic              stat_ie_i,
  input  logic              master_ie_i,
  input  logic              clr_cmd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [NSRC-1:0] raw_vec;
  logic [NSRC-1:0] sync_vec;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] snap_vec;
  logic            pend;

  assign raw_vec = {brk_i, txund_i, cts_i, synch_i, dcd_i, zcnt_i};
  assign en_vec  = pick_enables(src_en_i);

  esl_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_vec),
    .q     (sync_vec)
  );

  esl_change_latch #(.W(NSRC)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sync_vec),
    .en    (en_vec),
    .clr   (clr_cmd_i),
    .snap  (snap_vec),
    .pend  (pend)
  );

  assign status_o = pack_status(snap_vec, txe_i, rxa_i);
  assign pend_o   = pend;
  assign irq_o    = pend & stat_ie_i & master_ie_i;
endmodule

// File: rtl/esl_status_latch_chk.sv
module esl_status_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_cmd_i,
  input logic       stat_ie_i,
  input logic       master_ie_i,
  input logic       txe_i,
  input logic       rxa_i,
  input logic [7:0] status_o,
  input logic       pend_o,
  input logic       irq_o
);
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_o && stat_ie_i && master_ie_i)); // R9

  AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && stat_ie_i && master_ie_i) |-> irq_o); // R9

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_cmd_i) |=> pend_o); // R5

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && $past(pend_o)) |-> ($stable(status_o[7:3]) && $stable(status_o[1]))); // R5

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && clr_cmd_i) |=> !pend_o); // R7

  AST_LIVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] == txe_i) && (status_o[0] == rxa_i)); // R6
endmodule

bind esl_status_latch esl_status_latch_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_cmd_i   (clr_cmd_i),
  .stat_ie_i   (stat_ie_i),
  .master_ie_i (master_ie_i),
  .txe_i       (txe_i),
  .rxa_i       (rxa_i),
  .status_o    (status_o),
  .pend_o      (pend_o),
  .irq_o       (irq_o)
);

// File: tb/test_esl_status_latch.sv
module test_esl_status_latch;
  localparam int CLK_PERIOD = 10;
  localparam int STG        = 2;
  localparam int RAND_CYC   = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] raw = '0;   // {brk, txund, cts, synch, dcd, zcnt}
  logic       txe = 1'b0, rxa = 1'b0;
  logic [7:0] src_en = '0;
  logic       stat_ie = 1'b0, master_ie = 1'b0, clr = 1'b0;
  logic [7:0] status;
  logic       pend, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esl_status_latch #(.SYNC_STAGES(STG)) i_esl_status_latch (
    .clk(clk), .rst_n(rst_n),
    .brk_i(raw[5]), .txund_i(raw[4]), .cts_i(raw[3]), .synch_i(raw[2]),
    .dcd_i(raw[1]), .zcnt_i(raw[0]), .txe_i(txe), .rxa_i(rxa),
    .src_en_i(src_en), .stat_ie_i(stat_ie), .master_ie_i(master_ie),
    .clr_cmd_i(clr), .status_o(status), .pend_o(pend), .irq_o(irq)
  );

  // ---- reference model, built from the requirements ----
  logic [5:0] m_pipe [STG];
  logic [5:0] m_snap;
  logic       m_pend;

  function automatic logic [5:0] en_of(input logic [7:0] e); // R10 positions
    return {e[7], e[6], e[5], e[4], e[3], e[1]};
  endfunction

  function automatic logic [7:0] stat_of(input logic [5:0] s, input logic t, input logic r); // R11
    return {s[5:1], t, s[0], r};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STG; i++) m_pipe[i] = '0;
      m_snap = '0;
      m_pend = 1'b0;
    end else begin
      if (m_pend) begin
        if (clr) m_pend = 1'b0;
      end else begin
        m_pend = |((m_pipe[STG-1] ^ m_snap) & en_of(src_en));
        m_snap = m_pipe[STG-1];
      end
      for (int i = STG-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = raw;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    check({tag, " status"}, 32'(status), 32'(stat_of(m_snap, txe, rxa)));
    check({tag, " pend"},   32'(pend),   32'(m_pend));
    check({tag, " irq"},    32'(irq),    32'(m_pend & stat_ie & master_ie));
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7));
    tick(3);
    check("R1 status", 32'(status), 32'h00);
    check("R1 pend", 32'(pend), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after release pend", 32'(pend), 0);

    src_en = 8'hFA; stat_ie = 1'b1; master_ie = 1'b1;
    raw[3] = 1'b1;                               // CTS rises
    tick(2);
    check("R2 not yet pending", 32'(pend), 0);
    tick(1);
    check("R2 pending on third edge", 32'(pend), 1);
    check("R11 cts bit", 32'(status), 32'h20);

    raw[3] = 1'b0;                               // drops while frozen
    tick(4);
    check("R5 snapshot held", 32'(status), 32'h20);
    check("R5 still pending", 32'(pend), 1);
    pulse_clr();
    check("R7 clear", 32'(pend), 0);
    check("R7 snapshot kept until rearm", 32'(status), 32'h20);
    tick(1);
    check("R8 re-pend on missed change", 32'(pend), 1);
    check("R3 falling level captured", 32'(status), 32'h00);
    pulse_clr();
    tick(3);
    check("R3 quiet after clear", 32'(pend), 0);

    src_en = 8'hF2;                              // carrier detect disabled
    raw[1] = 1'b1;
    tick(3);
    check("R4 masked change", 32'(pend), 0);
    check("R4 bit tracks input", 32'(status), 32'h08);

    src_en = 8'h05;                              // only unused enable bits
    raw[0] = 1'b1;
    tick(4);
    check("R10 unused enable bits", 32'(pend), 0);
    check("R10 status tracks", 32'(status), 32'h0A);

    src_en = 8'hFF;
    raw[5] = 1'b1;
    tick(3);
    check("R2 break pending", 32'(pend), 1);
    check("R11 break layout", 32'(status), 32'h8A);
    check("R9 irq both enables", 32'(irq), 1);
    master_ie = 1'b0; #1;
    check("R9 master off", 32'(irq), 0);
    master_ie = 1'b1; stat_ie = 1'b0; #1;
    check("R9 channel off", 32'(irq), 0);
    stat_ie = 1'b1; #1;
    check("R9 restored", 32'(irq), 1);

    txe = 1'b1; rxa = 1'b1; #1;
    check("R6 live bits while frozen", 32'(status), 32'h8F);
    pulse_clr();
    tick(2);
    check("R7 cleared", 32'(pend), 0);
    pulse_clr();                                 // clear with nothing pending
    check("R7 idle clear no effect", 32'(pend), 0);
    check("R7 idle clear status", 32'(status), 32'h8F);

    for (int c = 0; c < RAND_CYC; c++) begin
      @(negedge clk);
      check_model("R11 random");
      for (int b = 0; b < 6; b++) if ($urandom_range(15) == 0) raw[b] = ~raw[b];
      txe = 1'($urandom_range(1));
      rxa = 1'($urandom_range(1));
      clr = ($urandom_range(7) == 0);
      if ($urandom_range(63) == 0) src_en = 8'($urandom);
      if ($urandom_range(31) == 0) stat_ie = ~stat_ie;
      if ($urandom_range(31) == 0) master_ie = ~master_ie;
    end
    clr = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule